// File: doc/BRIEF.md
# CAN Mailbox Acceptance Filter

This block chooses which of a bank of message buffers takes a received CAN frame. After the receive path has decoded a frame, it presents the identifier, the IDE and RTR flags, the data length code and the first two payload bytes along with a one-cycle strobe. The filter then visits every mailbox configuration in turn, one per clock. A mailbox matches when it is enabled and set to receive, and its identifier format agrees with the frame. The identifier bits that its own acceptance mask selects must also agree, and so must the two payload bytes if it filters on them. When the scan ends, the filter gives a one-cycle done pulse with a hit flag and the index of the winning mailbox.

The bank holds 32 mailboxes in three fixed groups. Indices 0 to 7 only receive. Indices 8 to 23 receive or transmit according to a control bit. Indices 24 to 31 only transmit and never accept a frame. Software loads each mailbox through a simple write port that selects a mailbox and one of four fields.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, done, hit and hit_idx are 0 and every mailbox is disabled, so a frame gives a result with hit 0.
- R2: The mask field (cfg_field 1) selects which identifier bits take part in the comparison. A mask bit of 1 requires that the frame bit equal the stored bit. A mask bit of 0 ignores that bit.
- R3: A standard mailbox (control bit 1 clear) compares only frm_id[28:18], which carries the 11-bit identifier, and it matches only frames with frm_ide = 0.
- R4: An extended mailbox (control bit 1 set) compares all 29 bits of frm_id and matches only frames with frm_ide = 1.
- R5: Mailboxes 24 to 31 never match. Mailboxes 8 to 23 match only while control bit 2 (receive direction) is set. Mailboxes 0 to 7 receive whatever bit 2 holds.
- R6: A mailbox whose control bit 0 (enable) is clear never matches.
- R7: When more than one mailbox matches, hit_idx is the highest-numbered one.
- R8: With control bit 3 set, a mailbox also requires frm_rtr = 0, frm_dlc >= 2, and {frm_byte0, frm_byte1} equal to its data field (cfg_field 3, cfg_wdata[15:8] = first byte, [7:0] = second byte). Otherwise it does not match.
- R9: A remote frame (frm_rtr = 1) is accepted by a receive mailbox that does not filter on data.
- R10: The filter accepts a strobe in any cycle in which no scan is running. It then pulses done for exactly one cycle, at the 32nd rising edge after the accepting edge. hit and hit_idx change only together with done and hold their values in between.
- R11: A strobe that arrives while a scan is running is ignored and does not change that scan's result.
- R12: Writes use cfg_field 0 for the identifier, 1 for the mask, 2 for control (cfg_wdata[3:0]) and 3 for the data bytes. A write on the same edge at which the scan examines that mailbox takes effect after the examination, so the scan uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mb | input | 5 | Mailbox addressed by the write |
| cfg_field | input | 2 | Field select: 0 id, 1 mask, 2 control, 3 data |
| cfg_wdata | input | 29 | Write data |
| frm_valid | input | 1 | Decoded frame strobe |
| frm_id | input | 29 | Frame identifier (standard in bits 28:18) |
| frm_ide | input | 1 | Extended-format flag |
| frm_rtr | input | 1 | Remote-request flag |
| frm_dlc | input | 4 | Data length code |
| frm_byte0 | input | 8 | First payload byte |
| frm_byte1 | input | 8 | Second payload byte |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | A mailbox accepted the frame |
| hit_idx | output | 5 | Winning mailbox index |

## Verification
Two things can happen on the same edge: a scan examines a mailbox, and software rewrites that same mailbox. The bench arranges this by timing a control write so that it lands on the edge at which the scan reaches the mailbox. It also times a second write one edge earlier. A second pair of overlapping events is a new strobe that arrives while a scan is running and another that arrives in the cycle done is high. A behavioural model in the bench works out what each case should give and compares done, hit and hit_idx with the design on every clock.

// File: rtl/can_accept_filter.sv
module can_accept_filter #(
  parameter int NUM_MB  = 32,
  parameter int RX_ONLY = 8,
  parameter int TX_ONLY = 8,
  parameter int IDW     = 29,
  parameter int STDW    = 11,
  parameter int IW      = $clog2(NUM_MB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_mb,
  input  logic [1:0]     cfg_field,
  input  logic [IDW-1:0] cfg_wdata,
  input  logic           frm_valid,
  input  logic [IDW-1:0] frm_id,
  input  logic           frm_ide,
  input  logic           frm_rtr,
  input  logic [3:0]     frm_dlc,
  input  logic [7:0]     frm_byte0,
  input  logic [7:0]     frm_byte1,
  output logic           done,
  output logic           hit,
  output logic [IW-1:0]  hit_idx
);
  localparam logic [IW-1:0]  LAST    = IW'(NUM_MB - 1);
  localparam logic [IW-1:0]  CFG_LO  = IW'(RX_ONLY);
  localparam logic [IW-1:0]  TX_LO   = IW'(NUM_MB - TX_ONLY);
  localparam logic [IDW-1:0] STD_SEL = {{STDW{1'b1}}, {(IDW-STDW){1'b0}}};

  logic [IDW-1:0] mb_id   [NUM_MB];
  logic [IDW-1:0] mb_mask [NUM_MB];
  logic [15:0]    mb_data [NUM_MB];
  logic [3:0]     mb_ctl  [NUM_MB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MB; i++) mb_ctl[i] <= '0;
    end else if (cfg_we && cfg_field == 2'd2) begin
      mb_ctl[cfg_mb] <= cfg_wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      case (cfg_field)
        2'd0:    mb_id[cfg_mb]   <= cfg_wdata;
        2'd1:    mb_mask[cfg_mb] <= cfg_wdata;
        2'd3:    mb_data[cfg_mb] <= cfg_wdata[15:0];
        default: ;
      endcase
    end
  end

  logic           busy, best_hit;
  logic [IW-1:0]  cnt, best_idx;
  logic [IDW-1:0] lat_id;
  logic           lat_ide, lat_rtr;
  logic [3:0]     lat_dlc;
  logic [15:0]    lat_bytes;

  wire [3:0]     ctl     = mb_ctl[cnt];
  wire           is_rx   = (cnt < CFG_LO) ? 1'b1 : (cnt >= TX_LO) ? 1'b0 : ctl[2];
  wire [IDW-1:0] sel     = ctl[1] ? {IDW{1'b1}} : STD_SEL;
  wire           id_ok   = ((lat_id ^ mb_id[cnt]) & mb_mask[cnt] & sel) == '0;
  wire           data_ok = !ctl[3] ||
                           (!lat_rtr && lat_dlc >= 4'd2 && lat_bytes == mb_data[cnt]);
  wire           match   = ctl[0] && is_rx && (ctl[1] == lat_ide) && id_ok && data_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; done <= 1'b0; hit <= 1'b0; hit_idx <= '0;
      best_hit <= 1'b0; best_idx <= '0;
      lat_id <= '0; lat_ide <= 1'b0; lat_rtr <= 1'b0; lat_dlc <= '0; lat_bytes <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && frm_valid) begin
        busy <= 1'b1; cnt <= '0; best_hit <= 1'b0;
        lat_id <= frm_id; lat_ide <= frm_ide; lat_rtr <= frm_rtr;
        lat_dlc <= frm_dlc; lat_bytes <= {frm_byte0, frm_byte1};
      end else if (busy) begin
        if (match) begin
          best_hit <= 1'b1; best_idx <= cnt;
        end
        if (cnt == LAST) begin
          busy <= 1'b0; done <= 1'b1;
          hit <= match || best_hit;
          hit_idx <= match ? cnt : best_idx;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hit) && $stable(hit_idx)); // R10
  AST_NO_TX_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> hit_idx < TX_LO); // R5
  AST_BUSY_IGNORES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frm_valid |=> $stable(lat_id) && $stable(lat_bytes)); // R11
  AST_DONE_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_mb = '0;
  logic [1:0]  cfg_field = '0;
  logic [28:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic [28:0] frm_id = '0;
  logic        frm_ide = 1'b0, frm_rtr = 1'b0;
  logic [3:0]  frm_dlc = '0;
  logic [7:0]  frm_byte0 = '0, frm_byte1 = '0;
  logic        done, hit;
  logic [4:0]  hit_idx;

  can_accept_filter uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  int m_id[32], m_mask[32], m_data[32], m_ctl[32];
  bit m_busy, m_bhit, m_done, m_hit;
  int m_cnt, m_bidx, m_idx;
  int f_id, f_dlc, f_bytes;
  bit f_ide, f_rtr;

  function automatic bit mb_match(int k);
    int lo;
    if (!m_ctl[k][0]) return 0;
    if (k >= 24) return 0;
    if (k >= 8 && !m_ctl[k][2]) return 0;
    if (m_ctl[k][1] != f_ide) return 0;
    lo = m_ctl[k][1] ? 0 : 18;
    for (int b = lo; b <= 28; b++)
      if (m_mask[k][b] && (m_id[k][b] != f_id[b])) return 0;
    if (m_ctl[k][3] && (f_rtr || f_dlc < 2 || f_bytes != m_data[k])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hit = 0; m_idx = 0; m_cnt = 0; m_bhit = 0; m_bidx = 0;
      for (int i = 0; i < 32; i++) m_ctl[i] = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (mb_match(m_cnt)) begin m_bhit = 1; m_bidx = m_cnt; end
        if (m_cnt == 31) begin
          m_busy = 0; m_done = 1; m_hit = m_bhit; m_idx = m_bidx;
        end else m_cnt++;
      end else if (frm_valid) begin
        m_busy = 1; m_cnt = 0; m_bhit = 0;
        f_id = int'(frm_id); f_ide = frm_ide; f_rtr = frm_rtr;
        f_dlc = int'(frm_dlc); f_bytes = {16'd0, frm_byte0, frm_byte1};
      end
      if (cfg_we) begin
        case (cfg_field)
          2'd0: m_id[cfg_mb] = int'(cfg_wdata);
          2'd1: m_mask[cfg_mb] = int'(cfg_wdata);
          2'd2: m_ctl[cfg_mb] = int'(cfg_wdata[3:0]);
          default: m_data[cfg_mb] = int'(cfg_wdata[15:0]);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (done !== m_done) begin
      fails++;
      $display("FAIL R10 done: actual %0b expected %0b at cycle %0d", done, m_done, cycles);
    end
    checks++;
    if (hit !== m_hit || hit_idx !== m_idx[4:0]) begin
      fails++;
      $display("FAIL %s hit/idx: actual %0b/%0d expected %0b/%0d at cycle %0d",
               cur_req, hit, hit_idx, m_hit, m_idx, cycles);
    end
  end

  task automatic cfg(input int mb, input int f, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_mb = mb[4:0]; cfg_field = f[1:0]; cfg_wdata = d[28:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe(input int id, input bit ide, input bit rtr, input int dlc,
                        input int b0, input int b1);
    @(negedge clk);
    frm_valid = 1; frm_id = id[28:0]; frm_ide = ide; frm_rtr = rtr;
    frm_dlc = dlc[3:0]; frm_byte0 = b0[7:0]; frm_byte1 = b1[7:0];
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic frame(input string req, input int id, input bit ide, input bit rtr,
                       input int dlc, input int b0, input int b1);
    cur_req = req;
    strobe(id, ide, rtr, dlc, b0, b1);
    repeat (34) @(negedge clk);
  endtask

  localparam int STDM = 29'h1FFC0000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    frame("R1", 0, 0, 0, 8, 0, 0);
    cfg(3, 0, 'h123 << 18); cfg(3, 1, STDM); cfg(3, 2, 'b0001);
    frame("R3", 'h123 << 18, 0, 0, 8, 0, 0);
    frame("R3", 'h123 << 18, 1, 0, 8, 0, 0);
    frame("R3", ('h123 << 18) | 'h2BEEF, 0, 0, 8, 0, 0);
    cfg(3, 1, STDM & ~(1 << 18));
    frame("R2", 'h122 << 18, 0, 0, 8, 0, 0);
    frame("R2", 'h121 << 18, 0, 0, 8, 0, 0);
    cfg(5, 0, 'h1ABCDE12); cfg(5, 1, 'h1FFFFFFF); cfg(5, 2, 'b0011);
    frame("R4", 'h1ABCDE12, 1, 0, 8, 0, 0);
    frame("R4", 'h1ABCDE13, 1, 0, 8, 0, 0);
    frame("R4", 'h1ABCDE12, 0, 0, 8, 0, 0);
    cfg(12, 0, 'h123 << 18); cfg(12, 1, STDM); cfg(12, 2, 'b0101);
    frame("R7", 'h123 << 18, 0, 0, 8, 0, 0);
    cfg(12, 2, 'b0001);
    frame("R5", 'h123 << 18, 0, 0, 8, 0, 0);
    cfg(28, 0, 'h123 << 18); cfg(28, 1, STDM); cfg(28, 2, 'b0101);
    frame("R5", 'h123 << 18, 0, 0, 8, 0, 0);
    cfg(3, 2, 'b0000);
    frame("R6", 'h123 << 18, 0, 0, 8, 0, 0);
    cfg(15, 0, 'h200 << 18); cfg(15, 1, STDM); cfg(15, 3, 'hA55A); cfg(15, 2, 'b1101);
    frame("R8", 'h200 << 18, 0, 0, 8, 'hA5, 'h5A);
    frame("R8", 'h200 << 18, 0, 0, 8, 'hA5, 'h5B);
    frame("R8", 'h200 << 18, 0, 0, 1, 'hA5, 'h5A);
    frame("R8", 'h200 << 18, 0, 1, 8, 'hA5, 'h5A);
    cfg(16, 0, 'h300 << 18); cfg(16, 1, STDM); cfg(16, 2, 'b0101);
    frame("R9", 'h300 << 18, 0, 1, 0, 0, 0);
    cur_req = "R11";
    strobe('h300 << 18, 0, 1, 0, 0, 0);
    repeat (4) @(negedge clk);
    strobe('h200 << 18, 0, 0, 8, 'hA5, 'h5A);
    repeat (24) @(negedge clk);
    frm_valid = 1; frm_id = 29'('h200 << 18); frm_ide = 0; frm_rtr = 0;
    frm_dlc = 8; frm_byte0 = 'hA5; frm_byte1 = 'h5A;
    repeat (6) @(negedge clk);
    frm_valid = 0;
    repeat (36) @(negedge clk);
    cfg(20, 0, 'h055 << 18); cfg(20, 1, STDM); cfg(20, 2, 'b0101);
    cur_req = "R12";
    strobe('h055 << 18, 0, 0, 8, 0, 0);
    repeat (20) @(negedge clk);
    cfg_we = 1; cfg_mb = 20; cfg_field = 2; cfg_wdata = 0;
    @(negedge clk); cfg_we = 0;
    repeat (16) @(negedge clk);
    cfg(20, 2, 'b0101);
    strobe('h055 << 18, 0, 0, 8, 0, 0);
    repeat (19) @(negedge clk);
    cfg_we = 1; cfg_mb = 20; cfg_field = 2; cfg_wdata = 0;
    @(negedge clk); cfg_we = 0;
    repeat (16) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule